// File: doc/BRIEF.md
# Fault Isolation Register Unit

This block gathers hardware error indications into a 64-entry sticky fault register and steers every fault to one of four error classes. Error sources pulse individual input bits. The matching fault bit then stays set until software clears it. Each fault position has three programming bits: two action bits and one mask bit. Together they decide which class output a set fault reaches. The four classes are checkstop, recoverable error, attention and local checkstop.

Software reaches the unit through a small register bus. The bus gives access to the fault register, the two action registers, the mask register and a unit control register. The mask also has two alias write addresses: one ANDs the written data into the mask and the other ORs it in. Because of these aliases, software can unmask or mask a group of sources with a single write and no read-modify-write. A bit in the control register sends attentions out either as special attention or as host attention.

Bus address map, with a 3-bit address:

| Address | Register |
|---|---|
| 0 | fault |
| 1 | action-0 |
| 2 | action-1 |
| 3 | mask |
| 4 | mask AND-alias |
| 5 | mask OR-alias |
| 6 | control, bit 0 |
| 7 | unused, reads 0 |

Top module: `fault_isolation_unit`

## Requirements
- R1: The fault, action-0, action-1 and mask registers are each NBITS (default 64) wide, one bit per source. A read request (bus_valid_i=1, bus_we_i=0) returns the addressed value on bus_rdata_o with bus_rvalid_o=1 in the following cycle. The addresses are 0 fault, 1 action-0, 2 action-1, 3 mask, 6 control.
- R2: Fault bits are sticky. An err_i pulse sets its bit at the next clock edge. If a software write to the fault register lands in the same cycle, the hardware set wins over a write that would clear that bit.
- R3: A write to address 0 replaces the fault register. Writing zero clears every bit. Writing back a read value with one bit cleared clears only that bit.
- R4: A set, unmasked fault whose pair (action-0 bit, action-1 bit) is (0,0) drives checkstop_o. A pair of (0,1) drives recov_o.
- R5: A set, unmasked fault with pair (1,0) drives attention. A fault with pair (1,1) drives lxstop_o.
- R6: A mask bit of 1 keeps its fault from every class output, whatever its action bits hold.
- R7: A write to address 3 replaces the mask. A write to address 4 ANDs the data into the mask. A write to address 5 ORs the data into the mask. Reads of addresses 4 and 5 return the current mask.
- R8: Control bit 0 (address 6) selects the attention port. When it is 0, attention leaves on spec_attn_o. When it is 1, attention leaves on host_attn_o. The two are never high together.
- R9: After reset, the mask reads all ones and the fault, action and control registers read zero. All class outputs are low.
- R10: Class outputs are registered. An output rises one cycle after its fault bit latches, and falls one cycle after the fault is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | NBITS | Hardware error pulses, one per fault position |
| bus_valid_i | input | 1 | Bus request strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | NBITS | Write data |
| bus_rdata_o | output | NBITS | Read data, valid when bus_rvalid_o is high |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| checkstop_o | output | 1 | Checkstop class active |
| recov_o | output | 1 | Recoverable-error class active |
| spec_attn_o | output | 1 | Attention class, special routing |
| host_attn_o | output | 1 | Attention class, host routing |
| lxstop_o | output | 1 | Local-checkstop class active |

## Verification
The hardest case to reach from the ports is a hardware error pulse that lands in the same cycle as a software write clearing the fault register. Here the set must win for that bit, and every other bit must still be cleared. The bench lines up both events on one clock edge by driving err_i and the bus write at the same falling edge. It then reads the fault register back through the scoreboard. Class routing is checked by programming a distinct action pair on four sources. The bench then unmasks each source in turn, using the AND alias before and the OR alias after. Each output is sampled at one cycle and at two cycles after the pulse, which checks the registered timing.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
    localparam int FIU_AW = 3;

    localparam logic [FIU_AW-1:0] ADR_FAULT    = 3'd0;
    localparam logic [FIU_AW-1:0] ADR_ACT0     = 3'd1;
    localparam logic [FIU_AW-1:0] ADR_ACT1     = 3'd2;
    localparam logic [FIU_AW-1:0] ADR_MASK     = 3'd3;
    localparam logic [FIU_AW-1:0] ADR_MASK_AND = 3'd4;
    localparam logic [FIU_AW-1:0] ADR_MASK_OR  = 3'd5;
    localparam logic [FIU_AW-1:0] ADR_CTRL     = 3'd6;

    // class index equals the action pair {action0, action1}
    typedef enum logic [1:0] {
        CLS_XSTOP  = 2'b00,
        CLS_RECOV  = 2'b01,
        CLS_ATTN   = 2'b10,
        CLS_LXSTOP = 2'b11
    } fiu_class_e;

    localparam int NUM_CLASSES = 4;

    typedef struct packed {
        logic xstop;
        logic recov;
        logic spec_attn;
        logic host_attn;
        logic lxstop;
    } fiu_out_t;
endpackage

// File: rtl/fiu_regfile.sv
module fiu_regfile
    import fiu_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBITS-1:0]  err_i,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [FIU_AW-1:0] bus_addr_i,
    input  logic [NBITS-1:0]  bus_wdata_i,
    output logic [NBITS-1:0]  fault_o,
    output logic [NBITS-1:0]  act0_o,
    output logic [NBITS-1:0]  act1_o,
    output logic [NBITS-1:0]  mask_o,
    output logic              host_sel_o,
    output logic [NBITS-1:0]  rdata_o,
    output logic              rvalid_o
);
    typedef struct packed {
        logic [NBITS-1:0] fault;
        logic [NBITS-1:0] act0;
        logic [NBITS-1:0] act1;
        logic [NBITS-1:0] mask;
        logic             host_sel;
        logic [NBITS-1:0] rdata;
        logic             rvalid;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_en, rd_en;
    assign wr_en = bus_valid_i &  bus_we_i;
    assign rd_en = bus_valid_i & ~bus_we_i;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = rd_en;

        if (wr_en) begin
            unique case (bus_addr_i)
                ADR_FAULT:    r_d.fault    = bus_wdata_i;
                ADR_ACT0:     r_d.act0     = bus_wdata_i;
                ADR_ACT1:     r_d.act1     = bus_wdata_i;
                ADR_MASK:     r_d.mask     = bus_wdata_i;
                ADR_MASK_AND: r_d.mask     = r_q.mask & bus_wdata_i;
                ADR_MASK_OR:  r_d.mask     = r_q.mask | bus_wdata_i;
                ADR_CTRL:     r_d.host_sel = bus_wdata_i[0];
                default:      ;
            endcase
        end

        // hardware set dominates any software clear in the same cycle
        r_d.fault = r_d.fault | err_i;

        if (rd_en) begin
            unique case (bus_addr_i)
                ADR_FAULT:    r_d.rdata = r_q.fault;
                ADR_ACT0:     r_d.rdata = r_q.act0;
                ADR_ACT1:     r_d.rdata = r_q.act1;
                ADR_MASK,
                ADR_MASK_AND,
                ADR_MASK_OR:  r_d.rdata = r_q.mask;
                ADR_CTRL:     r_d.rdata = {{(NBITS-1){1'b0}}, r_q.host_sel};
                default:      r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.mask     <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign fault_o    = r_q.fault;
    assign act0_o     = r_q.act0;
    assign act1_o     = r_q.act1;
    assign mask_o     = r_q.mask;
    assign host_sel_o = r_q.host_sel;
    assign rdata_o    = r_q.rdata;
    assign rvalid_o   = r_q.rvalid;
endmodule

// File: rtl/fiu_classify.sv
module fiu_classify
    import fiu_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic [NBITS-1:0]       fault_i,
    input  logic [NBITS-1:0]       act0_i,
    input  logic [NBITS-1:0]       act1_i,
    input  logic [NBITS-1:0]       mask_i,
    output logic [NUM_CLASSES-1:0] hit_o
);
    logic [NBITS-1:0] live;
    assign live = fault_i & ~mask_i;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        localparam logic [1:0] CODE = c[1:0];
        logic [NBITS-1:0] sel;
        assign sel      = (CODE[1] ? act0_i : ~act0_i) & (CODE[0] ? act1_i : ~act1_i);
        assign hit_o[c] = |(live & sel);
    end
endmodule

// File: rtl/fault_isolation_unit.sv
module fault_isolation_unit
    import fiu_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBITS-1:0]  err_i,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [NBITS-1:0]  bus_wdata_i,
    output logic [NBITS-1:0]  bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              checkstop_o,
    output logic              recov_o,
    output logic              spec_attn_o,
    output logic              host_attn_o,
    output logic              lxstop_o
);
    logic [NBITS-1:0]       fault_q, act0_q, act1_q, mask_q;
    logic                   host_sel_q;
    logic [NUM_CLASSES-1:0] hit;

    fiu_regfile #(.NBITS(NBITS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_i       (err_i),
        .bus_valid_i (bus_valid_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .fault_o     (fault_q),
        .act0_o      (act0_q),
        .act1_o      (act1_q),
        .mask_o      (mask_q),
        .host_sel_o  (host_sel_q),
        .rdata_o     (bus_rdata_o),
        .rvalid_o    (bus_rvalid_o)
    );

    fiu_classify #(.NBITS(NBITS)) u_cls (
        .fault_i (fault_q),
        .act0_i  (act0_q),
        .act1_i  (act1_q),
        .mask_i  (mask_q),
        .hit_o   (hit)
    );

    fiu_out_t out_d, out_q;

    always_comb begin
        out_d.xstop     = hit[CLS_XSTOP];
        out_d.recov     = hit[CLS_RECOV];
        out_d.spec_attn = hit[CLS_ATTN] & ~host_sel_q;
        out_d.host_attn = hit[CLS_ATTN] &  host_sel_q;
        out_d.lxstop    = hit[CLS_LXSTOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign checkstop_o = out_q.xstop;
    assign recov_o     = out_q.recov;
    assign spec_attn_o = out_q.spec_attn;
    assign host_attn_o = out_q.host_attn;
    assign lxstop_o    = out_q.lxstop;
endmodule

// File: rtl/fiu_checker.sv
module fiu_checker #(
    parameter int NBITS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBITS-1:0] err_i,
    input logic             bus_valid_i,
    input logic             bus_we_i,
    input logic [2:0]       bus_addr_i,
    input logic [NBITS-1:0] bus_wdata_i,
    input logic [NBITS-1:0] fault_q,
    input logic [NBITS-1:0] mask_q,
    input logic             checkstop_o,
    input logic             recov_o,
    input logic             spec_attn_o,
    input logic             host_attn_o,
    input logic             lxstop_o
);
    logic fault_wr, and_wr, or_wr;
    assign fault_wr = bus_valid_i & bus_we_i & (bus_addr_i == 3'd0);
    assign and_wr   = bus_valid_i & bus_we_i & (bus_addr_i == 3'd4);
    assign or_wr    = bus_valid_i & bus_we_i & (bus_addr_i == 3'd5);

    assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault_q & $past(err_i)) == $past(err_i)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_wr |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

    assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_q & ~mask_q) == '0) |=>
            !(checkstop_o | recov_o | spec_attn_o | host_attn_o | lxstop_o));

    assert_mask_and_R7: assert property (@(posedge clk) disable iff (!rst_n)
        and_wr |=> (mask_q == ($past(mask_q) & $past(bus_wdata_i))));

    assert_mask_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        or_wr |=> (mask_q == ($past(mask_q) | $past(bus_wdata_i))));

    assert_attn_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(spec_attn_o && host_attn_o));
endmodule

bind fault_isolation_unit fiu_checker #(.NBITS(NBITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_i       (err_i),
    .bus_valid_i (bus_valid_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .fault_q     (fault_q),
    .mask_q      (mask_q),
    .checkstop_o (checkstop_o),
    .recov_o     (recov_o),
    .spec_attn_o (spec_attn_o),
    .host_attn_o (host_attn_o),
    .lxstop_o    (lxstop_o)
);

// File: tb/fault_isolation_unit_tb.sv
module fault_isolation_unit_tb;
    localparam int NBITS = 64;

    logic             clk = 0;
    logic             rst_n = 0;
    logic [NBITS-1:0] err_i = '0;
    logic             bus_valid_i = 0;
    logic             bus_we_i = 0;
    logic [2:0]       bus_addr_i = '0;
    logic [NBITS-1:0] bus_wdata_i = '0;
    logic [NBITS-1:0] bus_rdata_o;
    logic             bus_rvalid_o;
    logic             checkstop_o, recov_o, spec_attn_o, host_attn_o, lxstop_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fault_isolation_unit #(.NBITS(NBITS)) u_dut (.*);

    typedef struct {
        logic [NBITS-1:0] exp;
        string            tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    // scoreboard monitor: compare read returns against queued expectations
    always @(negedge clk) begin
        if (rst_n && bus_rvalid_o) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL read with no expectation: actual %h expected none", bus_rdata_o);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata_o !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata_o, it.exp);
                end
            end
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [2:0] a, logic [NBITS-1:0] d);
        bus_valid_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
        cyc();
        bus_valid_i = 0; bus_we_i = 0;
    endtask

    task automatic bus_read(logic [2:0] a, logic [NBITS-1:0] exp, string tag);
        sb_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_valid_i = 1; bus_we_i = 0; bus_addr_i = a;
        cyc();
        bus_valid_i = 0;
        cyc();
    endtask

    task automatic pulse(int b);
        err_i = '0; err_i[b] = 1'b1;
        cyc();
        err_i = '0;
    endtask

    // outputs packed as {checkstop, recov, spec_attn, host_attn, lxstop}
    task automatic check_out(logic [4:0] exp, string tag);
        logic [4:0] act;
        act = {checkstop_o, recov_o, spec_attn_o, host_attn_o, lxstop_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [NBITS-1:0] bit_at(int b);
        return {{(NBITS-1){1'b0}}, 1'b1} << b;
    endfunction

    initial begin
        logic [NBITS-1:0] a0, a1;
        cyc(2);
        rst_n = 1;
        cyc();
        // R9 reset state
        check_out(5'b00000, "R9 outputs after reset");
        bus_read(3'd3, '1, "R9 mask resets to ones");
        bus_read(3'd0, '0, "R9 fault resets to zero");
        bus_read(3'd6, '0, "R9 control resets to zero");

        // program actions: bit3 (0,0), bit10 (0,1), bit20 (1,0), bit63 (1,1)
        a0 = bit_at(20) | bit_at(63);
        a1 = bit_at(10) | bit_at(63);
        bus_write(3'd1, a0);
        bus_write(3'd2, a1);
        bus_read(3'd1, a0, "R1 action-0 readback");
        bus_read(3'd2, a1, "R1 action-1 readback");

        // masked fault latches but stays silent
        pulse(3);
        cyc();
        check_out(5'b00000, "R6 masked fault silent");
        bus_read(3'd0, bit_at(3), "R2 fault bit latched");

        // unmask bit 3 through AND alias
        bus_write(3'd4, ~bit_at(3));
        cyc();
        check_out(5'b10000, "R4 (0,0) drives checkstop");
        bus_read(3'd4, ~bit_at(3), "R7 AND alias read returns mask");
        bus_write(3'd0, '0);
        cyc();
        check_out(5'b00000, "R3 write zero clears outputs");
        bus_read(3'd0, '0, "R3 write zero clears fault");

        // recoverable path, plus registered timing
        bus_write(3'd4, ~bit_at(10));
        pulse(10);
        check_out(5'b00000, "R10 output not yet high");
        cyc();
        check_out(5'b01000, "R4 (0,1) drives recov / R10 one cycle later");

        // attention: special then host
        bus_write(3'd4, ~bit_at(20));
        pulse(20);
        cyc();
        check_out(5'b01100, "R5 (1,0) drives attention on special (R8 ctl=0)");
        bus_write(3'd6, 64'd1);
        cyc();
        check_out(5'b01010, "R8 ctl=1 routes attention to host");

        // local checkstop
        bus_write(3'd4, ~bit_at(63));
        pulse(63);
        cyc();
        check_out(5'b01011, "R5 (1,1) drives local checkstop");

        // re-mask via OR alias
        bus_write(3'd5, bit_at(63) | bit_at(10));
        cyc();
        check_out(5'b00010, "R7 OR alias masks bits");
        bus_read(3'd5, ~(bit_at(3) | bit_at(20)), "R7 OR alias read returns mask");

        // single-bit clear via writeback
        bus_read(3'd0, bit_at(10) | bit_at(20) | bit_at(63), "R3 fault before writeback");
        bus_write(3'd0, bit_at(10) | bit_at(63));
        cyc();
        check_out(5'b00000, "R3 writeback clears one bit");
        bus_read(3'd0, bit_at(10) | bit_at(63), "R3 only that bit cleared");

        // hardware set wins over simultaneous clear
        err_i = bit_at(5);
        bus_write(3'd0, '0);
        err_i = '0;
        bus_read(3'd0, bit_at(5), "R2 set wins over same-cycle clear");

        // direct mask write
        bus_write(3'd3, 64'h0);
        cyc();
        check_out(5'b10000, "R7 direct mask write unmasks all (bit5 checkstop)");
        bus_read(3'd3, '0, "R7 direct mask readback");

        cyc(2);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R1 reads missing: actual %0d pending expected 0", sb_q.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule